// File: doc/BRIEF.md
# Keypad Digit Capture Register

This block gathers encoded keypad digits into a fixed set of four 4-bit slots and presents them side by side as one 16-bit code word, ready for comparison against a stored password. A one-cycle key strobe comes with a 4-bit digit code. The digit is written into the slot that the write pointer selects, and the pointer then moves on to the next slot. When the last slot has been filled, the pointer goes back to the first slot, so the fifth digit overwrites the first one.

A clear input empties every slot and sends the pointer back to the first slot. Clear wins over a key strobe in the same cycle. The block expects a strobe that has already been debounced and encoded. Keypad scanning and key-code conversion are done elsewhere.

Top module: `keycode_capture`

## Requirements
- R1: After reset the code output is all zeros and the next digit goes into slot 0.
- R2: A key strobe writes its 4-bit digit into exactly one slot. The code output shows it from the cycle after the strobe edge.
- R3: Slot 0 occupies code bits [15:12], slot 1 bits [11:8], slot 2 bits [7:4] and slot 3 bits [3:0].
- R4: Successive strobes fill slots 0, 1, 2, 3 in that order, and the slots not yet written keep their values.
- R5: The strobe after slot 3 has been written goes into slot 0 and overwrites its earlier value. The other slots are unchanged.
- R6: Clear sets every slot to zero and makes slot 0 the next write target.
- R7: When clear and a key strobe occur in the same cycle, clear takes effect and the digit is discarded.
- R8: In a cycle without a strobe or clear, the code output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_stb_i | input | 1 | One-cycle pulse: a digit is valid |
| key_code_i | input | 4 | Binary digit code |
| clear_i | input | 1 | Empty all slots and rewind the pointer |
| code_o | output | 16 | Assembled four-digit code |

## Verification
A corrupted write pointer shows up on the next strobe, when the digit appears in the wrong nibble of `code_o`. The bench writes distinct digits so that every misplaced nibble is visible in the cycle right after the strobe. A wrap that goes wrong only shows once five or more digits have been entered, and a clear that leaves the pointer unchanged only shows on the first digit after the clear. Both cases are exercised directly. Slots that change when they should not are exposed by comparing the whole code word, never just one nibble.

// File: rtl/keycode_pkg.sv
package keycode_pkg;
    parameter int unsigned DIGIT_W   = 4;
    parameter int unsigned NUM_SLOTS = 4;
    localparam int unsigned PTR_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int unsigned CODE_W = DIGIT_W * NUM_SLOTS;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [PTR_W-1:0]   ptr_t;
endpackage

// File: rtl/keycode_ptr.sv
module keycode_ptr
    import keycode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic clear_i,
    output ptr_t ptr_o
);
    localparam ptr_t LAST = ptr_t'(NUM_SLOTS - 1);

    typedef struct packed {
        ptr_t ptr;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.ptr = '0;
        end else if (adv_i) begin
            s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr_o = s_q.ptr;

    // R5: the pointer advances by one or wraps from the last slot to 0
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i) |=> (ptr_o == (($past(ptr_o) == LAST) ? ptr_t'(0) : ptr_t'($past(ptr_o) + 1'b1))));
    // R6: clear rewinds the pointer
    assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ptr_o == '0));
    assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_o <= LAST);
endmodule

// File: rtl/keycode_slots.sv
module keycode_slots
    import keycode_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] wr_sel_i,
    input  digit_t               wr_data_i,
    input  logic                 clear_i,
    output logic [CODE_W-1:0]    code_o
);
    typedef struct packed {
        digit_t [NUM_SLOTS-1:0] slot;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (clear_i)          s_d.slot[i] = '0;
            else if (wr_sel_i[i]) s_d.slot[i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // slot 0 is the most significant nibble
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pack
        assign code_o[CODE_W-1-g*DIGIT_W -: DIGIT_W] = s_q.slot[g];
    end

    // R2: at most one slot is written per cycle
    assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel_i));
    // R8: with no write and no clear the contents stay put
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel_i == '0 && !clear_i) |=> $stable(code_o));
    // R6: clear empties the slots
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (code_o == '0));
endmodule

// File: rtl/keycode_capture.sv
module keycode_capture
    import keycode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_stb_i,
    input  logic [3:0]  key_code_i,
    input  logic        clear_i,
    output logic [15:0] code_o
);
    ptr_t                 wr_ptr;
    logic [NUM_SLOTS-1:0] wr_sel;
    logic                 wr_en;

    // R7: a clear in the same cycle discards the strobe
    assign wr_en = key_stb_i && !clear_i;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (wr_ptr == ptr_t'(g));
    end

    keycode_ptr i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (wr_en),
        .clear_i (clear_i),
        .ptr_o   (wr_ptr)
    );

    keycode_slots i_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel_i  (wr_sel),
        .wr_data_i (digit_t'(key_code_i)),
        .clear_i   (clear_i),
        .code_o    (code_o)
    );

    // R2: a written digit appears in the nibble that the pointer selected
    assert_digit_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (code_o[15-4*$past(wr_ptr) -: 4] == $past(key_code_i)));
    // R7: a clear together with a strobe leaves the code empty
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && key_stb_i) |=> (code_o == 16'h0));
endmodule

// File: tb/test_keycode_capture.sv
module test_keycode_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_stb_i = 1'b0;
    logic [3:0]  key_code_i = '0;
    logic        clear_i = 1'b0;
    logic [15:0] code_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    keycode_capture i_keycode_capture (
        .clk(clk), .rst_n(rst_n), .key_stb_i(key_stb_i),
        .key_code_i(key_code_i), .clear_i(clear_i), .code_o(code_o)
    );

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (code_o !== exp) begin
            fails++;
            $display("FAIL %s: code_o=%h expected %h", req, code_o, exp);
        end
    endtask

    // drive on the falling edge, sample after the next rising edge
    task automatic key(input logic [3:0] d);
        @(negedge clk); key_stb_i = 1'b1; key_code_i = d;
        @(negedge clk); key_stb_i = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", 16'h0000);
        key(4'h9);
        check("R1", 16'h9000);
        clr();
    endtask

    task automatic t_fill();
        key(4'h1); check("R2", 16'h1000);
        key(4'h2); check("R4", 16'h1200);
        key(4'h3); check("R4", 16'h1230);
        key(4'h4); check("R3", 16'h1234);
    endtask

    task automatic t_wrap();
        key(4'hA); check("R5", 16'hA234);
        key(4'hB); check("R5", 16'hAB34);
        key(4'hC); key(4'hD); key(4'hE);
        check("R5", 16'hEBCD);
    endtask

    task automatic t_hold();
        repeat (5) @(negedge clk);
        check("R8", 16'hEBCD);
    endtask

    task automatic t_clear();
        clr(); check("R6", 16'h0000);
        key(4'h7); check("R6", 16'h7000);
        key(4'h8); clr();
        key(4'h5); check("R6", 16'h5000);
    endtask

    task automatic t_clear_wins();
        @(negedge clk); clear_i = 1'b1; key_stb_i = 1'b1; key_code_i = 4'hF;
        @(negedge clk); clear_i = 1'b0; key_stb_i = 1'b0;
        check("R7", 16'h0000);
        key(4'h6); check("R7", 16'h6000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_wrap();
        t_hold();
        t_clear();
        t_clear_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (10000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule